// File: doc/BRIEF.md
# Integer Execute Stage with Immediate Operand Handling

This block is the single-cycle execute stage of a 32-bit load-store RISC core. Each cycle it takes an already decoded operation code, three 5-bit register indices and the 16-bit immediate field of the instruction. It reads its two source operands from an internal 32-entry register file and computes a 32-bit result. It also presents the index of the destination register. On the rising clock edge the result is written back to that register when the write-enable input is high.

The operations are register-register add and subtract, add with immediate, signed set-less-than against an immediate, load-upper-immediate and OR with immediate. Each operation treats its immediate differently. Because the register file is inside the block, dependent sequences run through the same ports. One example is an upper-half load followed by an OR that fills in the low half to build a full 32-bit constant. Register 0 is hard-wired to zero.

Top module: `int_exec_unit`

## Requirements
- R1: With opCode 0 (add), result = value(rsIdx) + value(rtIdx) modulo 2^32, with no trap or flag on overflow.
- R2: With opCode 1 (subtract), result = value(rsIdx) - value(rtIdx) modulo 2^32.
- R3: With opCode 2 (add immediate), imm is sign-extended from bit 15 and added to value(rsIdx) modulo 2^32.
- R4: With opCode 3 (set-less-than immediate), result is 1 when value(rsIdx) is less than the sign-extended imm under a signed two's-complement compare, and 0 otherwise. Bits 31:1 are always 0.
- R5: With opCode 4 (load upper immediate), result[31:16] = imm and result[15:0] = 0. No register is read.
- R6: With opCode 5 (OR immediate), result = value(rsIdx) OR imm zero-extended to 32 bits, so result[31:16] = value(rsIdx)[31:16].
- R7: Register 0 always reads as zero, and a write whose destination is 0 is discarded.
- R8: Register reads are combinational. On a rising clock edge the current result is stored into register destIdx only when wrEn is high. With wrEn low no register changes.
- R9: destIdx equals rdIdx for opCodes 0 and 1, and rtIdx for opCodes 2 to 5. OpCodes 6 and 7 are no-operations: result is 0 and nothing is written even with wrEn high.
- R10: An active-low reset (rstN) clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 3 | Decoded operation (0 add, 1 sub, 2 add-imm, 3 slt-imm, 4 load-upper, 5 or-imm, 6/7 no-op) |
| wrEn | input | 1 | Write the result back at the next rising edge |
| rsIdx | input | 5 | First source register index |
| rtIdx | input | 5 | Second source index; destination for immediate forms |
| rdIdx | input | 5 | Destination index for register-register forms |
| imm | input | 16 | Immediate field of the instruction |
| result | output | 32 | Combinational execute result |
| destIdx | output | 5 | Selected destination register index |

## Verification
The bench aims at the signed compare boundaries: a negative operand against a zero immediate, the largest positive value against -1, and equal values. A design using an unsigned compare, or zero-extending the immediate, gives the opposite answer in some of these cases. An upper-half load followed by an OR-immediate whose bit 15 is set catches a sign-extending OR, because the upper half gets overwritten with ones. A load-upper that keeps stale low bits is caught in the same sequence. Writes to register 0, writes with wrEn low and no-op codes with wrEn high are each followed by a read of the affected register, so a leaking write shows up as a nonzero result. Add and subtract wrap-around catches any saturation or lost carry.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDI = 3'd2,
    OP_SLTI = 3'd3,
    OP_LUI  = 3'd4,
    OP_ORI  = 3'd5,
    OP_NOPA = 3'd6,
    OP_NOPB = 3'd7
  } opCode_e;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_SLT  = 3'd2,
    ALU_UPR  = 3'd3,
    ALU_OR   = 3'd4,
    ALU_ZERO = 3'd5
  } aluSel_e;

  // strobes from control to datapath
  typedef struct packed {
    aluSel_e aluSel;
    logic    useImm;
    logic    signExt;
    logic    destIsRd;
    logic    legal;
  } ctrl_t;

endpackage

// File: rtl/exu_control.sv
module exu_control
  import exu_pkg::*;
(
  input  logic [2:0] opCode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{aluSel: ALU_ZERO, useImm: 1'b0, signExt: 1'b0, destIsRd: 1'b0, legal: 1'b0};
    unique case (opCode_e'(opCode))
      OP_ADD:  ctrl = '{aluSel: ALU_ADD, useImm: 1'b0, signExt: 1'b0, destIsRd: 1'b1, legal: 1'b1};
      OP_SUB:  ctrl = '{aluSel: ALU_SUB, useImm: 1'b0, signExt: 1'b0, destIsRd: 1'b1, legal: 1'b1};
      OP_ADDI: ctrl = '{aluSel: ALU_ADD, useImm: 1'b1, signExt: 1'b1, destIsRd: 1'b0, legal: 1'b1};
      OP_SLTI: ctrl = '{aluSel: ALU_SLT, useImm: 1'b1, signExt: 1'b1, destIsRd: 1'b0, legal: 1'b1};
      OP_LUI:  ctrl = '{aluSel: ALU_UPR, useImm: 1'b1, signExt: 1'b0, destIsRd: 1'b0, legal: 1'b1};
      OP_ORI:  ctrl = '{aluSel: ALU_OR,  useImm: 1'b1, signExt: 1'b0, destIsRd: 1'b0, legal: 1'b1};
      default: ctrl = '{aluSel: ALU_ZERO, useImm: 1'b0, signExt: 1'b0, destIsRd: 1'b0, legal: 1'b0};
    endcase
  end

endmodule

// File: rtl/exu_regfile.sv
module exu_regfile #(
  parameter int XLEN = 32,
  parameter int REGS = 32,
  localparam int AW  = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   rAddrA,
  input  logic [AW-1:0]   rAddrB,
  output logic [XLEN-1:0] rDataA,
  output logic [XLEN-1:0] rDataB,
  input  logic            we,
  input  logic [AW-1:0]   wAddr,
  input  logic [XLEN-1:0] wData
);

  logic [XLEN-1:0] regMem [1:REGS-1];

  genvar gi;
  generate
    for (gi = 1; gi < REGS; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regMem[gi] <= '0;
        else if (we && wAddr == AW'(gi))
          regMem[gi] <= wData;
      end
    end
  endgenerate

  always_comb begin
    rDataA = (rAddrA == '0) ? '0 : regMem[rAddrA];
    rDataB = (rAddrB == '0) ? '0 : regMem[rAddrB];
  end

  // R8: a write to a nonzero register is visible on the next read of it
  a_r8_write_visible: assert property (@(posedge clk) disable iff (!rstN)
    (we && wAddr != '0 && rAddrA == wAddr) |=> (!$stable(rAddrA) || rDataA == $past(wData)));

  // R8: without a write, a held read address keeps its data
  a_r8_hold_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (!we) |=> (!$stable(rAddrA) || $stable(rDataA)));

  // R7: register zero never returns data
  a_r7_zero_read: assert property (@(posedge clk) disable iff (!rstN)
    (rAddrB == '0) |-> (rDataB == '0));

endmodule

// File: rtl/exu_datapath.sv
module exu_datapath
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctrl,
  input  logic [XLEN-1:0] rsVal,
  input  logic [XLEN-1:0] rtVal,
  input  logic [IMMW-1:0] imm,
  input  logic [AW-1:0]   rtIdx,
  input  logic [AW-1:0]   rdIdx,
  output logic [XLEN-1:0] result,
  output logic [AW-1:0]   destIdx
);

  localparam int EXTW = XLEN - IMMW;

  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] opB;
  logic [XLEN-1:0] sumOut;
  logic [XLEN-1:0] diffOut;
  logic            lessThan;

  always_comb begin
    immExt   = ctrl.signExt ? {{EXTW{imm[IMMW-1]}}, imm} : {{EXTW{1'b0}}, imm};
    opB      = ctrl.useImm ? immExt : rtVal;
    sumOut   = rsVal + opB;
    diffOut  = rsVal - opB;
    lessThan = $signed(rsVal) < $signed(opB);
    unique case (ctrl.aluSel)
      ALU_ADD: result = sumOut;
      ALU_SUB: result = diffOut;
      ALU_SLT: result = {{(XLEN-1){1'b0}}, lessThan};
      ALU_UPR: result = {imm, {EXTW{1'b0}}};
      ALU_OR:  result = rsVal | opB;
      default: result = '0;
    endcase
    destIdx = ctrl.destIsRd ? rdIdx : rtIdx;
  end

  // R4: compare result is a single bit
  a_r4_slt_bool: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.aluSel == ALU_SLT) |-> (result[XLEN-1:1] == '0));

  // R5: upper load leaves the low half clear and carries the immediate
  a_r5_upper_low_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.aluSel == ALU_UPR) |-> (result[EXTW-1:0] == '0 && result[XLEN-1:EXTW] == imm));

  // R6: OR-immediate never disturbs the upper half of the source
  a_r6_or_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.aluSel == ALU_OR) |-> (result[XLEN-1:IMMW] == rsVal[XLEN-1:IMMW]));

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  parameter int REGS = 32,
  localparam int AW  = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      opCode,
  input  logic            wrEn,
  input  logic [AW-1:0]   rsIdx,
  input  logic [AW-1:0]   rtIdx,
  input  logic [AW-1:0]   rdIdx,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] result,
  output logic [AW-1:0]   destIdx
);

  ctrl_t           ctrl;
  logic [XLEN-1:0] rsVal;
  logic [XLEN-1:0] rtVal;
  logic            regWe;

  exu_control u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  exu_regfile #(.XLEN(XLEN), .REGS(REGS)) u_rf (
    .clk    (clk),
    .rstN   (rstN),
    .rAddrA (rsIdx),
    .rAddrB (rtIdx),
    .rDataA (rsVal),
    .rDataB (rtVal),
    .we     (regWe),
    .wAddr  (destIdx),
    .wData  (result)
  );

  exu_datapath #(.XLEN(XLEN), .IMMW(IMMW), .AW(AW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .rsVal   (rsVal),
    .rtVal   (rtVal),
    .imm     (imm),
    .rtIdx   (rtIdx),
    .rdIdx   (rdIdx),
    .result  (result),
    .destIdx (destIdx)
  );

  assign regWe = wrEn && ctrl.legal;

  // R9: no-op codes produce zero
  a_r9_nop_zero: assert property (@(posedge clk) disable iff (!rstN)
    (opCode[2:1] == 2'b11) |-> (result == '0));

endmodule

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opCode = '0;
  logic        wrEn = 1'b0;
  logic [4:0]  rsIdx = '0, rtIdx = '0, rdIdx = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic [4:0]  destIdx;

  int checks = 0;
  int fails = 0;
  logic [31:0] model [32];

  always #5 clk = ~clk;

  int_exec_unit dut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .wrEn(wrEn),
    .rsIdx(rsIdx), .rtIdx(rtIdx), .rdIdx(rdIdx), .imm(imm),
    .result(result), .destIdx(destIdx)
  );

  function automatic logic [31:0] expResult(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [15:0] im);
    logic [31:0] se;
    se = {{16{im[15]}}, im};
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a + se;
      3'd3: return ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
      3'd4: return {im, 16'h0000};
      3'd5: return a | {16'h0000, im};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] op, input logic [4:0] rs, input logic [4:0] rt,
                      input logic [4:0] rd, input logic [15:0] im, input logic we, input string tag);
    logic [31:0] ev;
    logic [4:0]  ed;
    @(negedge clk);
    opCode = op; rsIdx = rs; rtIdx = rt; rdIdx = rd; imm = im; wrEn = we;
    #1;
    ev = expResult(op, model[rs], model[rt], im);
    ed = (op <= 3'd1) ? rd : rt;
    check(tag == "" ? reqOf(op) : tag, result, ev);
    if (op <= 3'd5) check("R9 dest", {27'd0, destIdx}, {27'd0, ed});
    @(posedge clk);
    if (we && op <= 3'd5 && ed != 5'd0) model[ed] = ev;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R10: registers cleared by reset
    doOp(3'd0, 5'd1, 5'd31, 5'd0, 16'h0, 1'b0, "R10 reset r1+r31");
    doOp(3'd0, 5'd17, 5'd9, 5'd0, 16'h0, 1'b0, "R10 reset r17+r9");

    // R5/R6: build constant 0xDEADBEEF in r5 (bit 15 of ORI imm set)
    doOp(3'd4, 5'd0, 5'd5, 5'd0, 16'hDEAD, 1'b1, "R5 upper load");
    doOp(3'd5, 5'd5, 5'd5, 5'd0, 16'hBEEF, 1'b1, "R6 or fill");
    doOp(3'd0, 5'd5, 5'd0, 5'd0, 16'h0, 1'b0, "R6 constant readback");
    // R5: upper load over a register with low bits set clears them
    doOp(3'd4, 5'd0, 5'd5, 5'd0, 16'h1234, 1'b1, "R5 low half cleared");
    doOp(3'd0, 5'd5, 5'd0, 5'd0, 16'h0, 1'b0, "R5 readback");

    // R3: negative immediate
    doOp(3'd2, 5'd0, 5'd6, 5'd0, 16'hFFFF, 1'b1, "R3 addi -1");
    doOp(3'd2, 5'd6, 5'd7, 5'd0, 16'h8000, 1'b1, "R3 addi -32768");
    // R1/R2 wrap
    doOp(3'd4, 5'd0, 5'd8, 5'd0, 16'h7FFF, 1'b1, "R5 load 7fff");
    doOp(3'd5, 5'd8, 5'd8, 5'd0, 16'hFFFF, 1'b1, "R6 fill ffff");
    doOp(3'd0, 5'd8, 5'd8, 5'd9, 16'h0, 1'b1, "R1 signed overflow wraps");
    doOp(3'd1, 5'd0, 5'd6, 5'd10, 16'h0, 1'b1, "R2 0 - (-1)");
    doOp(3'd1, 5'd0, 5'd10, 5'd11, 16'h0, 1'b1, "R2 0 - 1 wraps");

    // R4 boundaries: r6=-1, r8=0x7fffffff
    doOp(3'd3, 5'd6, 5'd12, 5'd0, 16'h0000, 1'b0, "R4 -1 < 0");
    doOp(3'd3, 5'd8, 5'd12, 5'd0, 16'hFFFF, 1'b0, "R4 max < -1");
    doOp(3'd3, 5'd6, 5'd12, 5'd0, 16'hFFFF, 1'b0, "R4 equal");
    doOp(3'd3, 5'd0, 5'd12, 5'd0, 16'h0001, 1'b0, "R4 0 < 1");

    // R7: write to r0 discarded
    doOp(3'd2, 5'd8, 5'd0, 5'd0, 16'h0055, 1'b1, "R7 write r0");
    doOp(3'd0, 5'd0, 5'd0, 5'd0, 16'h0, 1'b0, "R7 r0 reads zero");
    doOp(3'd0, 5'd1, 5'd8, 5'd0, 16'h0, 1'b1, "R7 add to r0");
    doOp(3'd5, 5'd0, 5'd0, 5'd0, 16'h0, 1'b0, "R7 r0 after add");
    // R8: wrEn low leaves register unchanged
    doOp(3'd4, 5'd0, 5'd13, 5'd0, 16'hABCD, 1'b0, "R8 no write");
    doOp(3'd0, 5'd13, 5'd0, 5'd0, 16'h0, 1'b0, "R8 reg unchanged");
    // R9: no-op with wrEn high
    doOp(3'd6, 5'd8, 5'd14, 5'd14, 16'h1111, 1'b1, "R9 nop6");
    doOp(3'd7, 5'd8, 5'd14, 5'd14, 16'h2222, 1'b1, "R9 nop7");
    doOp(3'd0, 5'd14, 5'd0, 5'd0, 16'h0, 1'b0, "R9 nop wrote nothing");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] rop;
      rop = 3'($urandom_range(0, 7));
      doOp(rop, 5'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
           ($urandom_range(0, 9) < 8), "");
    end

    summary();
  end

endmodule